// File: doc/BRIEF.md
# DTMF Period-Counting Tone Classifier

This block identifies the row and column frequencies of a dual-tone keypad signal. It does this by timing the two squared logic waveforms that zero-crossing comparators produce after band splitting. Each input is brought through a short synchronizer. The block then counts reference-clock cycles from one rising edge to the next and compares each measured period with a window around every nominal frequency of its group. The windows are derived at elaboration from the reference clock and a tolerance given in parts per thousand.

A group is declared matched only after a fixed number of consecutive periods have landed in the same window. The raw tone-present flag is high while both groups are matched. It is gated off when the fourth column is inhibited. A downstream steering block applies debounce timing and the final key encoding. Power-down clears all history and silences the output.

Top module: `dtmf_period_classifier`

## Requirements
- R1: A row tone within ±1.5% of 697, 770, 852 or 941 Hz, paired with a valid column tone, is reported on `row_idx` as 0, 1, 2 or 3 respectively.
- R2: A column tone within ±1.5% of 1209, 1336, 1477 or 1633 Hz, paired with a valid row tone, is reported on `col_idx` as 0, 1, 2 or 3 respectively.
- R3: If either group deviates from every nominal frequency of its group by 3.5% or more, `tone_present` stays low.
- R4: A group matches only after ACCEPT_PERIODS (default 4) consecutive in-window periods at the same frequency. The first rising edge after reset, silence or power-down measures no usable period, so on a fresh signal `tone_present` is still low just after the 4th rising edge and goes high a few cycles after the 5th.
- R5: A single period that falls outside every window clears that group's match, so `tone_present` falls a few cycles after the rising edge that closes the bad period. ACCEPT_PERIODS fresh good periods are then needed again.
- R6: If a group sees no rising edge for TIMEOUT cycles, its match clears. TIMEOUT = H + H*MARGIN_PCT/100, where H = floor(CLK_HZ*1000/(697*(1000-TOL_PM))). `tone_present` therefore stays high about 700 cycles after the last row edge and is low by 760 cycles (at CLK_HZ = 400000 and the defaults TOL_PM = 25, MARGIN_PCT = 25).
- R7: While `col4_inhibit` is high, a tone whose column index is 3 never raises `tone_present`; the gating acts in the same cycle. Columns 0 to 2 are unaffected by the inhibit.
- R8: While `pwr_down` is high, `tone_present` is low from the next cycle and all match history is cleared. After release, a fresh run of periods is required, as in R4.
- R9: After reset, `tone_present` is 0 and both indices are 0.
- R10: Whenever `tone_present` is low, `row_idx` and `col_idx` both read 0.
- R11: The period counters saturate instead of wrapping. A gap of any length counts as one out-of-window period and never as a valid one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all periods are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Holds all counters and match state cleared while high |
| col4_inhibit | input | 1 | Blocks reporting of the column index 3 tone |
| row_sq | input | 1 | Squared low-group waveform (asynchronous) |
| col_sq | input | 1 | Squared high-group waveform (asynchronous) |
| row_idx | output | 2 | Matched row index, 0 when no tone |
| col_idx | output | 2 | Matched column index, 0 when no tone |
| tone_present | output | 1 | Both groups currently matched and not inhibited |

## Verification
The hardest situation to reach from the ports is an exact boundary in the run of periods. One case is the difference between three and four accepted periods. The other is a single rogue period inside an otherwise steady tone. The bench drives each group from a free-running square-wave generator that counts the rising edges it produces. The stimulus waits on those edge counts, changes the period for exactly one cycle of the waveform, or stops a waveform right after a known edge. Outputs are then sampled a fixed few cycles after the edge that should or should not complete a match. Randomized trials cover the index mapping and the accept/reject tolerance bands.

// File: rtl/dtmf_cls_pkg.sv
package dtmf_cls_pkg;

  localparam int unsigned FREQS_PER_GROUP = 4;

  // Nominal tone frequency of a group slot.
  function automatic int unsigned nominal_hz(input bit is_col, input int unsigned slot);
    int unsigned f;
    if (!is_col) begin
      case (slot)
        0:       f = 697;
        1:       f = 770;
        2:       f = 852;
        default: f = 941;
      endcase
    end else begin
      case (slot)
        0:       f = 1209;
        1:       f = 1336;
        2:       f = 1477;
        default: f = 1633;
      endcase
    end
    return f;
  endfunction

  // Shortest accepted period: frequency raised by tol_pm parts per thousand.
  function automatic int unsigned period_lo(input int unsigned clk_hz, input int unsigned f,
                                            input int unsigned tol_pm);
    longint unsigned num, den;
    num = longint'(clk_hz) * 64'd1000;
    den = longint'(f) * longint'(1000 + tol_pm);
    return int'(num / den);
  endfunction

  // Longest accepted period: frequency lowered by tol_pm parts per thousand.
  function automatic int unsigned period_hi(input int unsigned clk_hz, input int unsigned f,
                                            input int unsigned tol_pm);
    longint unsigned num, den;
    num = longint'(clk_hz) * 64'd1000;
    den = longint'(f) * longint'(1000 - tol_pm);
    return int'(num / den);
  endfunction

  // Silence limit: longest row window plus a percentage margin.
  function automatic int unsigned silence_limit(input int unsigned clk_hz, input int unsigned tol_pm,
                                                input int unsigned margin_pct);
    int unsigned hi;
    hi = period_hi(clk_hz, nominal_hz(1'b0, 0), tol_pm);
    return hi + (hi * margin_pct) / 100;
  endfunction

endpackage

// File: rtl/dtmf_edge_timer.sv
module dtmf_edge_timer #(
  parameter int unsigned CNT_W       = 14,
  parameter int unsigned SYNC_STAGES = 2,   // must be 2 or more
  parameter int unsigned TIMEOUT     = 6000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sq_in,
  output logic             rise,
  output logic [CNT_W-1:0] count,
  output logic             stale
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] STALE_CNT = CNT_W'(TIMEOUT);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CNT_W-1:0]       cnt_q;

  assign rise  = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign count = cnt_q;
  assign stale = (cnt_q >= STALE_CNT);

  // Counter starts saturated so the first edge never yields a usable period.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= CNT_MAX;
    end else if (clr) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= CNT_MAX;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sq_in};
      prev_q <= sync_q[SYNC_STAGES-1];
      if (rise)                cnt_q <= CNT_W'(1);
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dtmf_window_match.sv
module dtmf_window_match
  import dtmf_cls_pkg::*;
#(
  parameter int unsigned CLK_HZ = 3579545,
  parameter int unsigned TOL_PM = 25,
  parameter bit          IS_COL = 1'b0,
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned ACCEPT = 4,
  parameter int unsigned RUN_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             period_vld,
  input  logic [CNT_W-1:0] period,
  input  logic             stale,
  output logic [1:0]       idx,
  output logic             match,
  output logic [RUN_W-1:0] run
);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(ACCEPT);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(ACCEPT - 1);

  logic [FREQS_PER_GROUP-1:0] hit;
  logic [1:0]                 hit_idx;
  logic                       found;

  for (genvar w = 0; w < FREQS_PER_GROUP; w++) begin : g_win
    localparam int unsigned LO = period_lo(CLK_HZ, nominal_hz(IS_COL, w), TOL_PM);
    localparam int unsigned HI = period_hi(CLK_HZ, nominal_hz(IS_COL, w), TOL_PM);
    assign hit[w] = (32'(period) >= LO) && (32'(period) <= HI);
  end

  // Windows are disjoint, so at most one bit of hit is set.
  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < FREQS_PER_GROUP; w++)
      if (hit[w]) hit_idx = 2'(w);
  end
  assign found = |hit;

  logic [1:0]       cand_q;
  logic [RUN_W-1:0] run_q;
  logic             match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q  <= '0;
      run_q   <= '0;
      match_q <= 1'b0;
    end else if (clr || stale) begin
      run_q   <= '0;
      match_q <= 1'b0;
    end else if (period_vld) begin
      if (!found) begin
        run_q   <= '0;
        match_q <= 1'b0;
      end else if (run_q != '0 && hit_idx == cand_q) begin
        if (run_q != RUN_FULL) run_q <= run_q + RUN_W'(1);
        match_q <= (run_q >= RUN_LAST);
      end else begin
        cand_q  <= hit_idx;
        run_q   <= RUN_W'(1);
        match_q <= (ACCEPT == 1);
      end
    end
  end

  assign idx   = cand_q;
  assign match = match_q;
  assign run   = run_q;
endmodule

// File: rtl/dtmf_period_classifier.sv
module dtmf_period_classifier
  import dtmf_cls_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 3579545,
  parameter int unsigned TOL_PM         = 25,
  parameter int unsigned ACCEPT_PERIODS = 4,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned MARGIN_PCT     = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down,
  input  logic       col4_inhibit,
  input  logic       row_sq,
  input  logic       col_sq,
  output logic [1:0] row_idx,
  output logic [1:0] col_idx,
  output logic       tone_present
);
  localparam int unsigned TIMEOUT = silence_limit(CLK_HZ, TOL_PM, MARGIN_PCT);
  localparam int unsigned CNT_W   = $clog2(TIMEOUT + 1) + 1;
  localparam int unsigned RUN_W   = $clog2(ACCEPT_PERIODS + 1);

  logic [1:0]       grp_sq;
  logic [1:0]       grp_rise;
  logic [1:0]       grp_stale;
  logic [1:0]       grp_match;
  logic [CNT_W-1:0] grp_cnt [2];
  logic [1:0]       grp_idx [2];
  logic [RUN_W-1:0] grp_run [2];

  assign grp_sq = {col_sq, row_sq};

  // Group 0 is the row group, group 1 the column group.
  for (genvar g = 0; g < 2; g++) begin : g_grp
    dtmf_edge_timer #(
      .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES), .TIMEOUT(TIMEOUT)
    ) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(pwr_down), .sq_in(grp_sq[g]),
      .rise(grp_rise[g]), .count(grp_cnt[g]), .stale(grp_stale[g])
    );
    dtmf_window_match #(
      .CLK_HZ(CLK_HZ), .TOL_PM(TOL_PM), .IS_COL(g == 1), .CNT_W(CNT_W),
      .ACCEPT(ACCEPT_PERIODS), .RUN_W(RUN_W)
    ) u_match (
      .clk(clk), .rst_n(rst_n), .clr(pwr_down), .period_vld(grp_rise[g]),
      .period(grp_cnt[g]), .stale(grp_stale[g]),
      .idx(grp_idx[g]), .match(grp_match[g]), .run(grp_run[g])
    );
  end

  // Named internal events for the checker.
  logic             row_rise, col_rise, row_stale, col_stale, row_match, col_match;
  logic [CNT_W-1:0] row_cnt, col_cnt;
  logic [RUN_W-1:0] row_run, col_run;
  logic [1:0]       col_cand;
  logic             col_blocked;

  assign row_rise  = grp_rise[0];
  assign col_rise  = grp_rise[1];
  assign row_stale = grp_stale[0];
  assign col_stale = grp_stale[1];
  assign row_match = grp_match[0];
  assign col_match = grp_match[1];
  assign row_cnt   = grp_cnt[0];
  assign col_cnt   = grp_cnt[1];
  assign row_run   = grp_run[0];
  assign col_run   = grp_run[1];
  assign col_cand  = grp_idx[1];

  assign col_blocked  = col4_inhibit && (col_cand == 2'd3);
  assign tone_present = row_match && col_match && !col_blocked;
  assign row_idx      = tone_present ? grp_idx[0] : 2'd0;
  assign col_idx      = tone_present ? grp_idx[1] : 2'd0;
endmodule

// File: rtl/dtmf_period_classifier_chk.sv
module dtmf_period_classifier_chk #(
  parameter int unsigned CNT_W  = 14,
  parameter int unsigned RUN_W  = 3,
  parameter int unsigned ACCEPT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             col4_inhibit,
  input logic             tone_present,
  input logic [1:0]       col_cand,
  input logic             row_rise,
  input logic             col_rise,
  input logic             row_stale,
  input logic             col_stale,
  input logic             row_match,
  input logic             col_match,
  input logic [CNT_W-1:0] row_cnt,
  input logic [CNT_W-1:0] col_cnt,
  input logic [RUN_W-1:0] row_run,
  input logic [RUN_W-1:0] col_run
);
  p_pd_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !tone_present);

  p_inhibit_col3_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col4_inhibit && col_cand == 2'd3) |-> !tone_present);

  p_row_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    row_stale |=> !row_match);

  p_col_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    col_stale |=> !col_match);

  p_row_run_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    row_match |-> (row_run == RUN_W'(ACCEPT)));

  p_col_run_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    col_match |-> (col_run == RUN_W'(ACCEPT)));

  p_match_on_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_match) |-> $past(row_rise));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_rise && !pwr_down) |=> (row_cnt >= $past(row_cnt)));

  p_col_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_rise && !pwr_down) |=> (col_cnt >= $past(col_cnt)));
endmodule

bind dtmf_period_classifier dtmf_period_classifier_chk #(
  .CNT_W(CNT_W), .RUN_W(RUN_W), .ACCEPT(ACCEPT_PERIODS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .col4_inhibit(col4_inhibit),
  .tone_present(tone_present), .col_cand(col_cand),
  .row_rise(row_rise), .col_rise(col_rise), .row_stale(row_stale), .col_stale(col_stale),
  .row_match(row_match), .col_match(col_match), .row_cnt(row_cnt), .col_cnt(col_cnt),
  .row_run(row_run), .col_run(col_run)
);

// File: tb/dtmf_period_classifier_tb.sv
module dtmf_period_classifier_tb;
  localparam int CLK_HZ = 400000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b0;
  logic col4_inhibit = 1'b0;
  logic row_sq, col_sq;
  logic [1:0] row_idx, col_idx;
  logic tone_present;

  int n_checks = 0;
  int n_err = 0;
  int row_per = 0, col_per = 0;
  int row_rises = 0, col_rises = 0;

  always #2 clk = ~clk;  // 250 MHz

  dtmf_period_classifier #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .col4_inhibit(col4_inhibit),
    .row_sq(row_sq), .col_sq(col_sq), .row_idx(row_idx), .col_idx(col_idx),
    .tone_present(tone_present)
  );

  function automatic int row_hz(input int i);
    int t[4] = '{697, 770, 852, 941};
    return t[i];
  endfunction
  function automatic int col_hz(input int i);
    int t[4] = '{1209, 1336, 1477, 1633};
    return t[i];
  endfunction
  // Period in cycles of a tone offset by dpm parts per thousand.
  function automatic int per_of(input int f, input int dpm);
    longint num, den;
    num = longint'(CLK_HZ) * 1000;
    den = longint'(f) * longint'(1000 + dpm);
    return int'(num / den);
  endfunction

  // Free-running square-wave generators, one driver per signal.
  initial begin
    row_sq = 1'b0;
    forever begin
      if (row_per == 0) begin
        row_sq = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = row_per;
        row_sq = 1'b1;
        row_rises++;
        repeat (p / 2) @(negedge clk);
        row_sq = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  initial begin
    col_sq = 1'b0;
    forever begin
      if (col_per == 0) begin
        col_sq = 1'b0;
        @(negedge clk);
      end else begin
        int p;
        p = col_per;
        col_sq = 1'b1;
        col_rises++;
        repeat (p / 2) @(negedge clk);
        col_sq = 1'b0;
        repeat (p - p / 2) @(negedge clk);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic after_row_rise(input int k);
    wait (row_rises >= k);
    repeat (5) @(negedge clk);
    #1;
  endtask

  task automatic silence(input int n);
    row_per = 0;
    col_per = 0;
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_up();
  end

  initial begin
    int base, rp, cp;
    void'($urandom(32'd7351));
    repeat (4) @(negedge clk);
    #1;
    chk("R9 present after reset", int'(tone_present), 0);
    chk("R9 row_idx after reset", int'(row_idx), 0);
    chk("R9 col_idx after reset", int'(col_idx), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 boundary: row 852 (idx 2), column 1336 (idx 1)
    rp = per_of(852, 0);
    cp = per_of(1336, 0);
    base = col_rises;
    col_per = cp;
    wait (col_rises >= base + 6);
    base = row_rises;
    row_per = rp;
    after_row_rise(base + 4);
    chk("R4 three periods not enough", int'(tone_present), 0);
    chk("R10 row_idx zero while absent", int'(row_idx), 0);
    after_row_rise(base + 5);
    chk("R4 fourth period accepts", int'(tone_present), 1);
    chk("R1 row 852 index", int'(row_idx), 2);
    chk("R2 col 1336 index", int'(col_idx), 1);

    // R5: one short period inside a steady tone
    base = row_rises + 1;
    wait (row_rises >= base);
    row_per = rp * 4 / 5;
    wait (row_rises >= base + 1);
    row_per = rp;
    after_row_rise(base + 2);
    chk("R5 bad period clears match", int'(tone_present), 0);
    after_row_rise(base + 5);
    chk("R5 three fresh periods not enough", int'(tone_present), 0);
    after_row_rise(base + 6);
    chk("R5 recovered after four periods", int'(tone_present), 1);

    // R6: stop the row right after an edge, column keeps running
    base = row_rises + 1;
    wait (row_rises >= base);
    row_per = 0;
    repeat (700) @(negedge clk);
    #1;
    chk("R6 still present before timeout", int'(tone_present), 1);
    repeat (60) @(negedge clk);
    #1;
    chk("R6 dropped after timeout", int'(tone_present), 0);
    silence(1000);

    // R11: long gap then three periods must not be enough
    repeat (6717) @(negedge clk);
    base = col_rises;
    col_per = cp;
    wait (col_rises >= base + 6);
    base = row_rises;
    row_per = rp;
    after_row_rise(base + 4);
    chk("R11 long gap not a valid period", int'(tone_present), 0);
    silence(1000);

    // R7: row 697, column 1633 with inhibit
    col4_inhibit = 1'b1;
    rp = per_of(697, 0);
    row_per = rp;
    col_per = per_of(1633, 0);
    base = row_rises;
    after_row_rise(base + 8);
    chk("R7 inhibited column 3", int'(tone_present), 0);
    col4_inhibit = 1'b0;
    #1;
    chk("R7 released inhibit present", int'(tone_present), 1);
    chk("R2 col 1633 index", int'(col_idx), 3);
    chk("R1 row 697 index", int'(row_idx), 0);
    col4_inhibit = 1'b1;
    #1;
    chk("R7 inhibit reapplied", int'(tone_present), 0);
    col_per = per_of(1209, 0);
    base = row_rises;
    after_row_rise(base + 8);
    chk("R7 inhibit ignores column 0", int'(tone_present), 1);
    chk("R2 col 1209 index", int'(col_idx), 0);
    col4_inhibit = 1'b0;

    // R8: power-down with tone applied
    pwr_down = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    chk("R8 power-down silences", int'(tone_present), 0);
    chk("R10 col_idx zero in power-down", int'(col_idx), 0);
    pwr_down = 1'b0;
    base = row_rises;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 history cleared", int'(tone_present), 0);
    after_row_rise(base + 7);
    chk("R8 recovers after release", int'(tone_present), 1);
    silence(1000);
    chk("R6 silent after both stop", int'(tone_present), 0);

    // Random trials: R1, R2, R3, R7
    for (int t = 0; t < 16; t++) begin
      int ri, ci, dr, dc, good, inh, exp;
      ri = int'($urandom_range(0, 3));
      ci = int'($urandom_range(0, 3));
      good = int'($urandom_range(0, 2) != 0);
      inh = int'($urandom_range(0, 3) == 0);
      dr = int'($urandom_range(0, 30)) - 15;
      dc = int'($urandom_range(0, 30)) - 15;
      if (!good) begin
        int mag;
        mag = int'($urandom_range(36, 60));
        if ($urandom_range(0, 1) != 0) mag = -mag;
        if ($urandom_range(0, 1) != 0) dr = mag;
        else dc = mag;
      end
      exp = (good != 0 && !(inh != 0 && ci == 3)) ? 1 : 0;
      col4_inhibit = (inh != 0);
      col_per = per_of(col_hz(ci), dc);
      row_per = per_of(row_hz(ri), dr);
      base = row_rises;
      after_row_rise(base + 7);
      chk(good != 0 ? "R1 R2 R7 random present" : "R3 random reject", int'(tone_present), exp);
      chk("R1 random row index", int'(row_idx), exp != 0 ? ri : 0);
      chk("R2 random col index", int'(col_idx), exp != 0 ? ci : 0);
      silence(1000);
    end
    col4_inhibit = 1'b0;
    finish_up();
  end
endmodule